// File: doc/BRIEF.md
# Trace Decode Signature Generator

This block sits behind the instruction decoder and compresses the control signals of every decoded instruction into a short signature, one per trace. It takes one decoded instruction per cycle. Each instruction brings a fixed-width vector of control signals that do not depend on operand values, its PC and a flag that marks a branch. The block folds each vector into a running accumulator with a bitwise XOR. Because the vectors do not depend on data, a fault-free repeat of the same trace always produces the same signature.

A trace closes when it takes in a branch, and that branch is the trace's last instruction. A trace also closes when it reaches a configurable instruction limit, 16 by default. The closed trace leaves through a registered valid/ready output that carries three things: the PC of the trace's first instruction, the signature and the instruction count. A downstream checker can then store or compare signatures keyed by start PC.

A flush input drops a partially built trace. If the output register still holds an unaccepted trace, decode input is held off until that trace is taken.

Top module: `trace_sig_gen`

## Requirements
- R1: After reset, `out_valid` is 0 and `in_ready` is 1.
- R2: `out_sig` equals the bitwise XOR of the `in_dec` vectors of all instructions accepted into that trace. No trace is emitted for instructions that did not close one.
- R3: An accepted instruction with `in_branch`=1 closes the current trace and is counted in it. The next accepted instruction opens a new trace.
- R4: A trace with no branch closes when it holds `MAX_LEN` instructions. The following instruction opens a new trace.
- R5: `out_pc` equals the `in_pc` of the first instruction accepted into the trace.
- R6: `out_cnt` is the number of instructions in the trace, always in the range 1 to `MAX_LEN`.
- R7: While `out_valid`=1 and `out_ready`=0, `in_ready` is 0 and `out_pc`, `out_sig` and `out_cnt` hold their values.
- R8: `flush`=1 discards the partial trace and clears the accumulator to zero. An instruction presented in the same cycle is ignored. A trace already in the output register is not affected.
- R9: Two traces with identical PCs and decode vectors produce identical signatures.
- R10: One clock edge after an accepted branch, `out_valid` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush | input | 1 | Discard the partial trace |
| in_valid | input | 1 | A decoded instruction is presented |
| in_ready | output | 1 | The block can take an instruction this cycle |
| in_dec | input | SIG_W | Decode control-signal vector |
| in_pc | input | PC_W | Instruction PC |
| in_branch | input | 1 | Instruction is a branch |
| out_valid | output | 1 | A closed trace is presented |
| out_ready | input | 1 | Consumer takes the trace |
| out_pc | output | PC_W | Start PC of the trace |
| out_sig | output | SIG_W | XOR signature of the trace |
| out_cnt | output | CNT_W | Instruction count of the trace |

## Verification
The bench builds the block with `SIG_W`=8, `PC_W`=12 and `MAX_LEN`=4. The small limit lets a sweep cover every run length from 1 to `MAX_LEN`+2, with and without a closing branch, so limit closes, branch closes and a branch that lands exactly on the limit all occur many times. That sweep is repeated under three consumer readiness patterns, which drives the stall and back-pressure paths. Flush in the middle of a trace and a repeated identical trace are then checked against an arithmetic model.

// File: rtl/trace_sig_pkg.sv
package trace_sig_pkg;
  localparam int unsigned DEF_SIG_W   = 32;
  localparam int unsigned DEF_PC_W    = 32;
  localparam int unsigned DEF_MAX_LEN = 16;

  function automatic int unsigned cnt_width(input int unsigned max_len);
    return $clog2(max_len + 1);
  endfunction
endpackage

// File: rtl/sig_accum.sv
module sig_accum #(
  parameter int unsigned SIG_W = 32,
  parameter int unsigned PC_W  = 32,
  parameter int unsigned CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             flush,
  input  logic             take,
  input  logic             close,
  input  logic [SIG_W-1:0] in_dec,
  input  logic [PC_W-1:0]  in_pc,
  output logic [SIG_W-1:0] nxt_sig,
  output logic [CNT_W-1:0] nxt_cnt,
  output logic [PC_W-1:0]  nxt_pc
);
  logic             open_q;
  logic [SIG_W-1:0] sig_q;
  logic [CNT_W-1:0] cnt_q;
  logic [PC_W-1:0]  pc_q;

  // Combined view: trace contents including the instruction on the input.
  always_comb begin
    nxt_sig = (open_q ? sig_q : '0) ^ in_dec;
    nxt_cnt = (open_q ? cnt_q : '0) + CNT_W'(1);
    nxt_pc  = open_q ? pc_q : in_pc;
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      open_q <= 1'b0;
      sig_q  <= '0;
      cnt_q  <= '0;
      pc_q   <= '0;
    end else if (take) begin
      if (close) begin
        open_q <= 1'b0;
        sig_q  <= '0;
        cnt_q  <= '0;
      end else begin
        open_q <= 1'b1;
        sig_q  <= nxt_sig;
        cnt_q  <= nxt_cnt;
        pc_q   <= nxt_pc;
      end
    end
  end
endmodule

// File: rtl/trace_boundary.sv
module trace_boundary #(
  parameter int unsigned MAX_LEN = 16,
  parameter int unsigned CNT_W   = 5
) (
  input  logic             in_branch,
  input  logic [CNT_W-1:0] nxt_cnt,
  output logic             close
);
  localparam logic [CNT_W-1:0] LIMIT = CNT_W'(MAX_LEN);

  always_comb close = in_branch || (nxt_cnt == LIMIT);
endmodule

// File: rtl/trace_out_stage.sv
module trace_out_stage #(
  parameter int unsigned SIG_W = 32,
  parameter int unsigned PC_W  = 32,
  parameter int unsigned CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [SIG_W-1:0] ld_sig,
  input  logic [PC_W-1:0]  ld_pc,
  input  logic [CNT_W-1:0] ld_cnt,
  input  logic             out_ready,
  output logic             out_valid,
  output logic [SIG_W-1:0] out_sig,
  output logic [PC_W-1:0]  out_pc,
  output logic [CNT_W-1:0] out_cnt,
  output logic             free
);
  always_comb free = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_sig   <= '0;
      out_pc    <= '0;
      out_cnt   <= '0;
    end else if (load) begin
      out_valid <= 1'b1;
      out_sig   <= ld_sig;
      out_pc    <= ld_pc;
      out_cnt   <= ld_cnt;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/trace_sig_gen.sv
module trace_sig_gen
  import trace_sig_pkg::*;
#(
  parameter int unsigned SIG_W   = DEF_SIG_W,
  parameter int unsigned PC_W    = DEF_PC_W,
  parameter int unsigned MAX_LEN = DEF_MAX_LEN,
  parameter int unsigned CNT_W   = cnt_width(MAX_LEN)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             flush,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [SIG_W-1:0] in_dec,
  input  logic [PC_W-1:0]  in_pc,
  input  logic             in_branch,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [PC_W-1:0]  out_pc,
  output logic [SIG_W-1:0] out_sig,
  output logic [CNT_W-1:0] out_cnt
);
  logic             take;
  logic             close;
  logic             free;
  logic [SIG_W-1:0] nxt_sig;
  logic [CNT_W-1:0] nxt_cnt;
  logic [PC_W-1:0]  nxt_pc;

  always_comb begin
    in_ready = free;
    take     = in_valid && free && !flush;
  end

  sig_accum #(.SIG_W(SIG_W), .PC_W(PC_W), .CNT_W(CNT_W)) u_accum (
    .clk(clk), .rst(rst), .flush(flush), .take(take), .close(close),
    .in_dec(in_dec), .in_pc(in_pc),
    .nxt_sig(nxt_sig), .nxt_cnt(nxt_cnt), .nxt_pc(nxt_pc)
  );

  trace_boundary #(.MAX_LEN(MAX_LEN), .CNT_W(CNT_W)) u_bound (
    .in_branch(in_branch), .nxt_cnt(nxt_cnt), .close(close)
  );

  trace_out_stage #(.SIG_W(SIG_W), .PC_W(PC_W), .CNT_W(CNT_W)) u_out (
    .clk(clk), .rst(rst), .load(take && close),
    .ld_sig(nxt_sig), .ld_pc(nxt_pc), .ld_cnt(nxt_cnt),
    .out_ready(out_ready), .out_valid(out_valid),
    .out_sig(out_sig), .out_pc(out_pc), .out_cnt(out_cnt), .free(free)
  );
endmodule

// File: rtl/trace_sig_checker.sv
module trace_sig_checker #(
  parameter int unsigned SIG_W   = 32,
  parameter int unsigned PC_W    = 32,
  parameter int unsigned MAX_LEN = 16,
  parameter int unsigned CNT_W   = 5
) (
  input logic             clk,
  input logic             rst,
  input logic             flush,
  input logic             in_valid,
  input logic             in_ready,
  input logic             in_branch,
  input logic             out_valid,
  input logic             out_ready,
  input logic [PC_W-1:0]  out_pc,
  input logic [SIG_W-1:0] out_sig,
  input logic [CNT_W-1:0] out_cnt
);
  a_r6_cnt_range: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_cnt >= CNT_W'(1)) && (out_cnt <= CNT_W'(MAX_LEN)));

  a_r7_hold: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=>
      (out_valid && $stable(out_pc) && $stable(out_sig) && $stable(out_cnt)));

  a_r7_backpressure: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |-> !in_ready);

  a_r10_branch_emits: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready && in_branch && !flush) |=> out_valid);
endmodule

bind trace_sig_gen trace_sig_checker #(
  .SIG_W(SIG_W), .PC_W(PC_W), .MAX_LEN(MAX_LEN), .CNT_W(CNT_W)
) u_trace_sig_checker (
  .clk(clk), .rst(rst), .flush(flush), .in_valid(in_valid),
  .in_ready(in_ready), .in_branch(in_branch), .out_valid(out_valid),
  .out_ready(out_ready), .out_pc(out_pc), .out_sig(out_sig), .out_cnt(out_cnt)
);

// File: tb/test_trace_sig_gen.sv
module test_trace_sig_gen;
  localparam int unsigned SIG_W   = 8;
  localparam int unsigned PC_W    = 12;
  localparam int unsigned MAX_LEN = 4;
  localparam int unsigned CNT_W   = $clog2(MAX_LEN + 1);
  localparam int NEXP = 1024;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic flush = 1'b0;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [SIG_W-1:0] in_dec = '0;
  logic [PC_W-1:0]  in_pc = '0;
  logic in_branch = 1'b0;
  logic out_valid;
  logic out_ready = 1'b1;
  logic [PC_W-1:0]  out_pc;
  logic [SIG_W-1:0] out_sig;
  logic [CNT_W-1:0] out_cnt;

  always #5 clk = ~clk;

  trace_sig_gen #(.SIG_W(SIG_W), .PC_W(PC_W), .MAX_LEN(MAX_LEN)) i_trace_sig_gen (
    .clk(clk), .rst(rst), .flush(flush), .in_valid(in_valid), .in_ready(in_ready),
    .in_dec(in_dec), .in_pc(in_pc), .in_branch(in_branch),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_pc(out_pc), .out_sig(out_sig), .out_cnt(out_cnt)
  );

  int n_chk = 0;
  int n_bad = 0;
  logic [PC_W-1:0]  e_pc  [NEXP];
  logic [SIG_W-1:0] e_sig [NEXP];
  int               e_cnt [NEXP];
  logic [SIG_W-1:0] g_sig [NEXP];
  int wr = 0;
  int rd = 0;

  logic [PC_W-1:0]  m_pc  = '0;
  logic [SIG_W-1:0] m_sig = '0;
  int               m_cnt = 0;
  int rmode = 0;
  int cyc = 0;
  logic done = 1'b0;

  task automatic check(input string req, input logic ok, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [SIG_W-1:0] gen_dec(input int n);
    return SIG_W'(n * 37 + (n >> 2) * 11 + 3);
  endfunction

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  // Send one instruction; update the model once it is accepted.
  task automatic send(input logic [PC_W-1:0] pc, input logic [SIG_W-1:0] dec, input logic br);
    @(negedge clk);
    in_valid = 1'b1; in_pc = pc; in_dec = dec; in_branch = br;
    #1;
    while (!in_ready) begin
      @(negedge clk);
      #1;
    end
    if (m_cnt == 0) m_pc = pc;
    m_sig = m_sig ^ dec;
    m_cnt++;
    if (br || m_cnt == MAX_LEN) begin
      e_pc[wr] = m_pc; e_sig[wr] = m_sig; e_cnt[wr] = m_cnt; wr++;
      m_sig = '0; m_cnt = 0;
    end
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0; in_branch = 1'b0;
  endtask

  // R8: flush with a junk instruction presented in the same cycle.
  task automatic do_flush();
    @(negedge clk);
    flush = 1'b1; in_valid = 1'b1; in_branch = 1'b1;
    in_pc = PC_W'(12'hABC); in_dec = SIG_W'(8'h5A);
    @(negedge clk);
    flush = 1'b0; in_valid = 1'b0; in_branch = 1'b0;
    m_sig = '0; m_cnt = 0;
  endtask

  // Output monitor: drives out_ready by pattern, compares accepted traces.
  initial begin : monitor
    int k;
    logic prev_stall;
    logic [PC_W-1:0]  p_pc;
    logic [SIG_W-1:0] p_sig;
    logic [CNT_W-1:0] p_cnt;
    k = 0;
    prev_stall = 1'b0;
    p_pc = '0; p_sig = '0; p_cnt = '0;
    forever begin
      @(negedge clk);
      k++;
      case (rmode)
        0: out_ready = 1'b1;
        1: out_ready = k[0];
        default: out_ready = (k % 4 == 0);
      endcase
      #2;
      if (!rst) begin
        if (prev_stall) begin
          check("R7 hold", out_valid && out_pc == p_pc && out_sig == p_sig && out_cnt == p_cnt,
                longint'(out_sig), longint'(p_sig));
        end
        if (out_valid && !out_ready) begin
          check("R7 backpressure", in_ready == 1'b0, longint'(in_ready), 0);
        end
        prev_stall = out_valid && !out_ready;
        p_pc = out_pc; p_sig = out_sig; p_cnt = out_cnt;
        if (out_valid && out_ready) begin
          if (rd >= wr) begin
            check("R2 unexpected trace", 1'b0, longint'(out_sig), 0);
          end else begin
            check("R2 signature", out_sig == e_sig[rd], longint'(out_sig), longint'(e_sig[rd]));
            check("R5 start pc", out_pc == e_pc[rd], longint'(out_pc), longint'(e_pc[rd]));
            check("R6 count", int'(out_cnt) == e_cnt[rd], longint'(out_cnt), longint'(e_cnt[rd]));
            g_sig[rd] = out_sig;
            rd++;
          end
        end
      end
    end
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000 && !done) begin
      n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      summary();
    end
  end

  initial begin : driver
    int pcb;
    int rep_a;
    int rep_b;
    pcb = 16;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    #1;
    check("R1 out_valid", out_valid == 1'b0, longint'(out_valid), 0);
    check("R1 in_ready", in_ready == 1'b1, longint'(in_ready), 1);

    // R3 R4: every run length, with and without closing branch, three ready patterns.
    for (int mode = 0; mode < 3; mode++) begin
      rmode = mode;
      for (int len = 1; len <= MAX_LEN + 2; len++) begin
        for (int brk = 0; brk < 2; brk++) begin
          for (int i = 0; i < len; i++) begin
            send(PC_W'(pcb), gen_dec(pcb), (brk == 1) && (i == len - 1));
            pcb++;
          end
        end
      end
      do_flush();
    end

    // R8: partial trace discarded, next trace starts fresh after the flush.
    rmode = 0;
    send(PC_W'(12'h100), 8'hF0, 1'b0);
    send(PC_W'(12'h101), 8'h0F, 1'b0);
    do_flush();
    send(PC_W'(12'h200), 8'h11, 1'b0);
    send(PC_W'(12'h201), 8'h22, 1'b0);
    send(PC_W'(12'h202), 8'h44, 1'b1);
    // R8: flush on an idle accumulator, then a single-instruction trace.
    do_flush();
    send(PC_W'(12'h300), 8'h81, 1'b1);

    // R9: the same trace twice gives the same signature.
    rmode = 1;
    rep_a = wr;
    send(PC_W'(12'h400), 8'h13, 1'b0);
    send(PC_W'(12'h401), 8'h37, 1'b0);
    send(PC_W'(12'h402), 8'hC5, 1'b1);
    rep_b = wr;
    send(PC_W'(12'h400), 8'h13, 1'b0);
    send(PC_W'(12'h401), 8'h37, 1'b0);
    send(PC_W'(12'h402), 8'hC5, 1'b1);

    rmode = 0;
    while (rd < wr) @(negedge clk);
    repeat (4) @(negedge clk);
    #3;
    check("R9 repeat", g_sig[rep_a] == g_sig[rep_b], longint'(g_sig[rep_b]), longint'(g_sig[rep_a]));
    check("R2 drained", rd == wr && out_valid == 1'b0, longint'(rd), longint'(wr));
    done = 1'b1;
    summary();
  end
endmodule